// File: doc/BRIEF.md
# DRAM Initialization and Refresh Scheduler

This block brings an asynchronous DRAM array out of power-up and then keeps its contents alive. After reset it holds off all traffic for a programmable pause, then drives a fixed number of warm-up strobe cycles of its own. Only then does it raise `ready_for_access` and let the access sequencer run. From then on an interval timer accrues owed refreshes. Each owed refresh is requested from the access sequencer through a request/grant pair. Once a grant is taken, the block drives the row and column strobes for one refresh cycle.

Three refresh styles can be selected at run time:
- column-before-row refresh, which uses the device's internal row counter;
- row-only refresh, where the block supplies the row from its own counter;
- hidden refresh, which follows a read whose column strobe the sequencer keeps low.

Up to a configurable number of refreshes may be owed and served in a burst. If an interval ends while the owed count is full, a sticky error flag is raised. The block also watches the row strobe at the device. If the strobe has stayed inactive longer than the retention limit, the block withdraws readiness and re-runs the warm-up. All times are parameters counted in clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held, `ready_for_access`, `ref_req`, `ref_own`, `ref_owed` and `deadline_err` are 0, and both strobes (`ref_ras_n`, `ref_cas_n`, active low) are 1.
- R2: After reset is released, no row-strobe falling edge occurs during the first INIT_PAUSE cycles.
- R3: After the pause, exactly WARMUP strobe cycles are driven, and then `ready_for_access` rises. `ref_req` is never 1 while `ready_for_access` is 0.
- R4: When `ref_mode` is 0 (column-before-row), the column strobe is low at every warm-up row-strobe fall. In any other mode the warm-up cycles are row-only, with the column strobe high at every fall.
- R5: While ready, `ref_owed` increments once every REF_INTERVAL cycles and saturates at MAX_OWED. The first increment comes REF_INTERVAL cycles after readiness. `ref_req` is 1 while owed is nonzero and no strobe cycle runs.
- R6: Each cycle with `ref_req` and `ref_grant` both 1 starts one refresh cycle and removes one owed refresh. A held grant serves a backlog back to back until owed reaches 0.
- R7: A refresh in mode 0 has three phases, in order:
  - the column strobe is low and the row strobe high for CSR cycles;
  - the row strobe is low for RAS_LOW cycles, with the column strobe still low for the first CHR of them;
  - both strobes are high for PRECH cycles.
- R8: A refresh in mode 1 has two phases: the row strobe is low for RAS_LOW cycles, then PRECH cycles of precharge, with the column strobe high throughout. `ref_row` is valid while the row strobe is low and advances by one after each such cycle, wrapping to 0 after 2^ROW_W-1.
- R9: A refresh in mode 2 (hidden) has three phases, in order:
  - the column strobe is low with the row strobe high for PRECH cycles;
  - both strobes are low for RAS_LOW cycles;
  - both strobes are high for PRECH cycles.
- R10: An interval that ends while owed equals MAX_OWED and no refresh is being granted sets `deadline_err`. The flag stays set until reset.
- R11: While ready, if the device row strobe (the block's own strobe or `acc_ras_active`) stays inactive for IDLE_LIMIT+1 consecutive cycles, `ready_for_access` falls. WARMUP warm-up cycles then run, readiness returns, and the owed count is preserved.
- R12: `ref_own` is 1 exactly in the cycles in which the block drives a strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_mode | input | 2 | 0 column-before-row, 1 row-only, 2 hidden, 3 treated as 0 |
| acc_ras_active | input | 1 | Access sequencer currently holds the row strobe low |
| ref_grant | input | 1 | Access sequencer grants the strobes to this block |
| ref_req | output | 1 | A refresh is owed and the block is free to run one |
| ready_for_access | output | 1 | Initialization complete; normal access allowed |
| ref_own | output | 1 | The block is driving a strobe cycle |
| ref_ras_n | output | 1 | Row strobe from this block, active low |
| ref_cas_n | output | 1 | Column strobe from this block, active low |
| ref_row | output | ROW_W | Row address for row-only refresh |
| ref_owed | output | clog2(MAX_OWED+1) | Number of refreshes currently owed |
| deadline_err | output | 1 | Sticky: a refresh deadline was missed |

## Verification
The assertions take three things for granted about the access sequencer:
- it grants only in cycles where `ref_req` is high;
- it drives `acc_ras_active` only while it really holds the row strobe;
- in hidden mode, it grants only while it keeps the column strobe of a finished read low.

The stimulus stays within these assumptions. It raises the grant only after seeing `ref_req` high at a falling edge, and then for a single cycle or for a deliberate held-grant burst. It keeps `acc_ras_active` low so that idle expiry is fully determined by the block's own strobe. It changes `ref_mode` only between refresh cycles.

// File: rtl/dram_ref_pkg.sv
// Shared types for the DRAM init/refresh scheduler.
package dram_ref_pkg;
    // Kind of strobe cycle the engine performs
    typedef enum logic [1:0] {
        K_CBR    = 2'd0,
        K_RONLY  = 2'd1,
        K_HIDDEN = 2'd2
    } ref_kind_e;

    // Phase of one strobe cycle
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_ACT   = 2'd2,
        PH_PRE   = 2'd3
    } phase_e;

    // Top-level initialization state
    typedef enum logic [1:0] {
        ST_PAUSE = 2'd0,
        ST_WARM  = 2'd1,
        ST_RUN   = 2'd2
    } init_st_e;
endpackage

// File: rtl/ref_strobe_engine.sv
// Strobe engine: runs one refresh/warm-up strobe cycle per start pulse.
// Kinds:
//   column-before-row = SETUP(CSR) -> ACT(RAS_LOW) -> PRE(PRECH)
//   row-only          = ACT -> PRE, with the row counter advancing at the end
//   hidden            = SETUP(PRECH, column low) -> ACT -> PRE
// Assumes start is pulsed only while busy is 0, CSR >= 1 and CHR <= RAS_LOW.
module ref_strobe_engine
    import dram_ref_pkg::*;
#(
    parameter int ROW_W   = 10,
    parameter int RAS_LOW = 6,
    parameter int PRECH   = 5,
    parameter int CSR     = 1,
    parameter int CHR     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  ref_kind_e        kind,
    output logic             busy,
    output logic             done,
    output logic             ras_n,
    output logic             cas_n,
    output logic [ROW_W-1:0] row
);
    localparam int M1 = (CSR > RAS_LOW) ? CSR : RAS_LOW;
    localparam int M2 = (M1 > PRECH) ? M1 : PRECH;
    localparam int CW = $clog2(M2 + 1);
    localparam logic [CW-1:0] ACT_LAST = CW'(RAS_LOW - 1);
    localparam logic [CW-1:0] PRE_LAST = CW'(PRECH - 1);
    localparam logic [CW-1:0] CBR_SET  = CW'(CSR - 1);
    localparam logic [CW-1:0] HID_SET  = CW'(PRECH - 1);
    localparam logic [CW-1:0] CHR_LIM  = CW'(CHR);

    phase_e           phase;
    logic [CW-1:0]    cnt;
    ref_kind_e        kind_q;
    logic [ROW_W-1:0] row_q;
    logic [CW-1:0]    setup_last;

    // Length of the setup phase depends on the latched kind
    always_comb setup_last = (kind_q == K_HIDDEN) ? HID_SET : CBR_SET;

    // Phase sequencer and row counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            kind_q <= K_CBR;
            row_q  <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    kind_q <= kind;
                    cnt    <= '0;
                    phase  <= (kind == K_RONLY) ? PH_ACT : PH_SETUP;
                end
                PH_SETUP: if (cnt == setup_last) begin
                    cnt   <= '0;
                    phase <= PH_ACT;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                PH_ACT: if (cnt == ACT_LAST) begin
                    cnt   <= '0;
                    phase <= PH_PRE;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: if (cnt == PRE_LAST) begin
                    cnt   <= '0;
                    phase <= PH_IDLE;
                    if (kind_q == K_RONLY) row_q <= row_q + 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    // Strobe decode from phase and kind
    always_comb begin
        busy  = (phase != PH_IDLE);
        done  = (phase == PH_PRE) && (cnt == PRE_LAST);
        ras_n = (phase != PH_ACT);
        case (kind_q)
            K_CBR:    cas_n = !((phase == PH_SETUP) || ((phase == PH_ACT) && (cnt < CHR_LIM)));
            K_HIDDEN: cas_n = !((phase == PH_SETUP) || (phase == PH_ACT));
            default:  cas_n = 1'b1;
        endcase
        row = row_q;
    end

    // Column strobe must already be low when the row strobe falls in column-before-row refresh
    assert_cbr_setup_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && kind_q == K_CBR) |-> !cas_n);

    // Row counter advances by one after each row-only cycle
    assert_row_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind_q == K_RONLY) |=> (row == $past(row) + 1'b1));

    // Row strobe is never dropped while the engine is idle
    assert_ras_owned_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> busy);

    generate
        if (RAS_LOW > 1) begin : g_act_min
            // A row strobe fall is followed by at least one further low cycle
            assert_act_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ras_n) |=> !ras_n);
        end
    endgenerate
endmodule

// File: rtl/ref_interval_timer.sv
// Interval timer and owed-refresh accounting.
// Ticks every REF_INTERVAL enabled cycles; owed saturates at MAX_OWED.
// A tick at saturation with no concurrent serve sets a sticky error.
// Assumes serve is asserted only while owed is nonzero.
module ref_interval_timer #(
    parameter int REF_INTERVAL = 1600,
    parameter int MAX_OWED     = 8,
    localparam int OW = $clog2(MAX_OWED + 1),
    localparam int TW = $clog2(REF_INTERVAL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          serve,
    output logic [OW-1:0] owed,
    output logic          err
);
    localparam logic [TW-1:0] T_LAST = TW'(REF_INTERVAL - 1);
    localparam logic [OW-1:0] O_MAX  = OW'(MAX_OWED);

    logic [TW-1:0] tcnt;
    logic          tick;

    // Tick when the enabled counter wraps
    always_comb tick = enable && (tcnt == T_LAST);

    // Interval counter, held at zero while disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) tcnt <= '0;
        else if (tick)         tcnt <= '0;
        else                   tcnt <= tcnt + 1'b1;
    end

    // Owed count and sticky deadline flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed <= '0;
            err  <= 1'b0;
        end else begin
            case ({tick, serve})
                2'b10:   if (owed != O_MAX) owed <= owed + 1'b1;
                2'b01:   owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
            if (tick && !serve && owed == O_MAX) err <= 1'b1;
        end
    end

    // The owed count never exceeds its ceiling
    assert_owed_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= O_MAX);

    // Once raised, the deadline flag holds until reset
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // A serve never comes with nothing owed
    assert_serve_owed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        serve |-> (owed != '0));
endmodule

// File: rtl/ref_idle_monitor.sv
// Watches the device row strobe; pulses expire after IDLE_LIMIT+1 consecutive inactive cycles while enabled.
// Assumes strobe_active reflects every row-strobe low cycle at the device.
module ref_idle_monitor #(
    parameter int IDLE_LIMIT = 1640000,
    localparam int IW = $clog2(IDLE_LIMIT + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic strobe_active,
    output logic expire
);
    localparam logic [IW-1:0] I_LIM = IW'(IDLE_LIMIT);

    logic [IW-1:0] icnt;

    // Expiry when the inactive run has reached the limit and continues
    always_comb expire = enable && !strobe_active && (icnt == I_LIM);

    // Inactive-cycle counter, cleared by activity, disable or expiry
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || strobe_active || expire) icnt <= '0;
        else                                              icnt <= icnt + 1'b1;
    end

    // Expiry is only reported while monitoring
    assert_expire_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> enable);
endmodule

// File: rtl/dram_refresh_sched.sv
// DRAM initialization and refresh scheduler (top).
// Sequence: pause -> WARMUP strobe cycles -> run. In run, owed refreshes are requested and,
// once granted, driven as strobe cycles. Long row-strobe inactivity re-enters warm-up.
// Assumes the access sequencer grants only while ref_req is high and merges this
// block's strobes with its own while ref_own is high.
module dram_refresh_sched
    import dram_ref_pkg::*;
#(
    parameter int INIT_PAUSE   = 50000,
    parameter int WARMUP       = 8,
    parameter int REF_INTERVAL = 1600,
    parameter int MAX_OWED     = 8,
    parameter int IDLE_LIMIT   = 1640000,
    parameter int RAS_LOW      = 6,
    parameter int PRECH        = 5,
    parameter int CSR          = 1,
    parameter int CHR          = 2,
    parameter int ROW_W        = 10,
    localparam int OW = $clog2(MAX_OWED + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       ref_mode,
    input  logic             acc_ras_active,
    input  logic             ref_grant,
    output logic             ref_req,
    output logic             ready_for_access,
    output logic             ref_own,
    output logic             ref_ras_n,
    output logic             ref_cas_n,
    output logic [ROW_W-1:0] ref_row,
    output logic [OW-1:0]    ref_owed,
    output logic             deadline_err
);
    localparam int PW = $clog2(INIT_PAUSE + 1);
    localparam int WW = $clog2(WARMUP + 1);
    localparam logic [PW-1:0] P_LAST = PW'(INIT_PAUSE - 1);
    localparam logic [WW-1:0] W_NUM  = WW'(WARMUP);

    init_st_e      st;
    logic [PW-1:0] pcnt;
    logic [WW-1:0] warm_left;
    ref_kind_e     mode_kind;
    ref_kind_e     eng_kind;
    logic          warm_start;
    logic          grant_take;
    logic          eng_start;
    logic          eng_busy;
    logic          eng_done;
    logic          eng_ras_n;
    logic          idle_expire;

    // Decode the selected refresh style
    always_comb begin
        case (ref_mode)
            2'd1:    mode_kind = K_RONLY;
            2'd2:    mode_kind = K_HIDDEN;
            default: mode_kind = K_CBR;
        endcase
    end

    // Start selection: warm-up cycles or granted refreshes
    always_comb begin
        ready_for_access = (st == ST_RUN);
        warm_start       = (st == ST_WARM) && (warm_left != '0) && !eng_busy;
        ref_req          = ready_for_access && (ref_owed != '0) && !eng_busy;
        grant_take       = ref_req && ref_grant;
        eng_start        = warm_start || grant_take;
        if (warm_start) eng_kind = (mode_kind == K_CBR) ? K_CBR : K_RONLY;
        else            eng_kind = mode_kind;
        ref_own   = eng_busy;
        ref_ras_n = eng_ras_n;
    end

    // Initialization state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_PAUSE;
            pcnt      <= '0;
            warm_left <= W_NUM;
        end else begin
            case (st)
                ST_PAUSE: if (pcnt == P_LAST) st <= ST_WARM;
                          else                pcnt <= pcnt + 1'b1;
                ST_WARM: begin
                    if (warm_start) warm_left <= warm_left - 1'b1;
                    else if (warm_left == '0 && !eng_busy) st <= ST_RUN;
                end
                default: if (idle_expire) begin
                    st        <= ST_WARM;
                    warm_left <= W_NUM;
                end
            endcase
        end
    end

    ref_strobe_engine #(
        .ROW_W(ROW_W), .RAS_LOW(RAS_LOW), .PRECH(PRECH), .CSR(CSR), .CHR(CHR)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .kind(eng_kind),
        .busy(eng_busy), .done(eng_done), .ras_n(eng_ras_n),
        .cas_n(ref_cas_n), .row(ref_row)
    );

    ref_interval_timer #(
        .REF_INTERVAL(REF_INTERVAL), .MAX_OWED(MAX_OWED)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .enable(ready_for_access), .serve(grant_take),
        .owed(ref_owed), .err(deadline_err)
    );

    ref_idle_monitor #(
        .IDLE_LIMIT(IDLE_LIMIT)
    ) u_idle (
        .clk(clk), .rst_n(rst_n), .enable(ready_for_access),
        .strobe_active(acc_ras_active || !eng_ras_n), .expire(idle_expire)
    );

    // No request is raised before initialization is complete
    assert_req_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> ready_for_access);

    // A taken grant puts the block in charge of the strobes next cycle
    assert_grant_own_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_grant) |=> ref_own);

    // Readiness only rises with the strobes free
    assert_ready_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_for_access) |-> !ref_own);

    // A cycle completion is only reported while owning the strobes
    assert_done_owned_R12: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |-> ref_own);
endmodule

// File: tb/sim_dram_refresh_sched.sv
// Directed bench for dram_refresh_sched: one task per scenario.
module sim_dram_refresh_sched;
    localparam int P_PAUSE = 100;
    localparam int P_WARM  = 8;
    localparam int P_INT   = 40;
    localparam int P_OWED  = 4;
    localparam int P_IDLE  = 400;
    localparam int P_RL    = 4;
    localparam int P_PR    = 3;
    localparam int P_CSR   = 1;
    localparam int P_CHR   = 2;
    localparam int P_ROW   = 4;
    localparam int OWW     = $clog2(P_OWED + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       ref_mode = 2'd0;
    logic             acc_ras_active = 1'b0;
    logic             ref_grant = 1'b0;
    logic             ref_req;
    logic             ready_for_access;
    logic             ref_own;
    logic             ref_ras_n;
    logic             ref_cas_n;
    logic [P_ROW-1:0] ref_row;
    logic [OWW-1:0]   ref_owed;
    logic             deadline_err;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    int exp_row = 0;

    always #5 clk = ~clk;

    dram_refresh_sched #(
        .INIT_PAUSE(P_PAUSE), .WARMUP(P_WARM), .REF_INTERVAL(P_INT), .MAX_OWED(P_OWED),
        .IDLE_LIMIT(P_IDLE), .RAS_LOW(P_RL), .PRECH(P_PR), .CSR(P_CSR), .CHR(P_CHR),
        .ROW_W(P_ROW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ref_mode(ref_mode), .acc_ras_active(acc_ras_active),
        .ref_grant(ref_grant), .ref_req(ref_req), .ready_for_access(ready_for_access),
        .ref_own(ref_own), .ref_ras_n(ref_ras_n), .ref_cas_n(ref_cas_n),
        .ref_row(ref_row), .ref_owed(ref_owed), .deadline_err(deadline_err)
    );

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int kind);
        if (kind == 0)      return P_CSR + P_RL + P_PR;
        else if (kind == 1) return P_RL + P_PR;
        else                return P_PR + P_RL + P_PR;
    endfunction

    // Expected {ras_n, cas_n} at sample i of a strobe cycle
    function automatic logic [1:0] exp_strobe(input int kind, input int i);
        if (kind == 0) begin
            if (i < P_CSR)        return 2'b10;
            if (i < P_CSR + P_RL) return {1'b0, (i - P_CSR) >= P_CHR};
            return 2'b11;
        end else if (kind == 1) begin
            if (i < P_RL) return 2'b01;
            return 2'b11;
        end else begin
            if (i < P_PR)        return 2'b10;
            if (i < P_PR + P_RL) return 2'b00;
            return 2'b11;
        end
    endfunction

    // R1: reset state
    task automatic do_reset(input logic [1:0] mode);
        ref_mode  = mode;
        ref_grant = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!ready_for_access && !ref_req && !ref_own && ref_ras_n && ref_cas_n
            && ref_owed == 0 && !deadline_err, "R1 reset state",
            {ready_for_access, ref_req, ref_own, ref_ras_n, ref_cas_n, deadline_err}, 6'b000110);
        rst_n = 1'b1;
    endtask

    // R2/R3/R4: pause, warm-up count and warm-up cycle kind
    task automatic check_init(input logic [1:0] mode);
        int cyc = 0;
        int falls = 0;
        int first_fall = -1;
        int bad_kind = 0;
        int early_req = 0;
        logic prev_ras = 1'b1;
        do_reset(mode);
        while (!ready_for_access && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (prev_ras && !ref_ras_n) begin
                falls++;
                if (first_fall < 0) first_fall = cyc;
                if ((mode == 2'd0) ? ref_cas_n : !ref_cas_n) bad_kind++;
            end
            if (ref_req && !ready_for_access) early_req++;
            prev_ras = ref_ras_n;
        end
        chk(first_fall >= P_PAUSE, "R2 first strobe after pause", first_fall, P_PAUSE);
        chk(falls == P_WARM, "R3 warm-up strobe count", falls, P_WARM);
        chk(early_req == 0, "R3 no request before ready", early_req, 0);
        chk(bad_kind == 0, "R4 warm-up cycle kind", bad_kind, 0);
    endtask

    // R6/R7/R8/R9/R12: grant one refresh and compare its strobe trace
    task automatic run_refresh(input int kind);
        int i = 0;
        int bad = 0;
        int wait_n = 0;
        logic [1:0] got;
        logic [1:0] want;
        while (!ref_req && wait_n < 1000) begin
            @(negedge clk);
            wait_n++;
        end
        ref_grant = 1'b1;
        @(negedge clk);
        ref_grant = 1'b0;
        while (ref_own && i < 64) begin
            got  = {ref_ras_n, ref_cas_n};
            want = exp_strobe(kind, i);
            if (got != want) begin
                if (bad == 0)
                    $display("FAIL R%0s strobe sample %0d actual=%b expected=%b",
                             (kind == 0) ? "7" : (kind == 1) ? "8" : "9", i, got, want);
                bad++;
            end
            if (kind == 1 && i == 0)
                chk(int'(ref_row) == exp_row, "R8 row address", ref_row, exp_row);
            i++;
            @(negedge clk);
        end
        n_chk++;
        if (bad != 0) n_fail++;
        chk(i == exp_len(kind), "R12 own window length", i, exp_len(kind));
        if (kind == 1) exp_row = (exp_row + 1) % (1 << P_ROW);
    endtask

    // R5/R10/R11: accrual, saturation, deadline and idle re-initialization
    task automatic test_accrual_idle();
        int k = 0;
        int t_first = -1;
        int t_drop = -1;
        int falls = 0;
        logic prev_ras = 1'b1;
        check_init(2'd0);
        while (k < 5 * P_INT - 1) begin
            @(negedge clk);
            k++;
            if (t_first < 0 && ref_owed == 1) t_first = k;
        end
        chk(t_first == P_INT, "R5 first accrual delay", t_first, P_INT);
        chk(ref_owed == P_OWED, "R5 saturation", ref_owed, P_OWED);
        chk(ref_req, "R5 request while owed", ref_req, 1);
        chk(!deadline_err, "R10 no error before deadline", deadline_err, 0);
        @(negedge clk);
        k++;
        chk(deadline_err, "R10 error at missed deadline", deadline_err, 1);
        while (ready_for_access && k < 2000) begin
            @(negedge clk);
            k++;
        end
        t_drop = k;
        chk(t_drop == P_IDLE + 1, "R11 idle expiry time", t_drop, P_IDLE + 1);
        while (!ready_for_access && k < 4000) begin
            @(negedge clk);
            k++;
            if (prev_ras && !ref_ras_n) falls++;
            prev_ras = ref_ras_n;
        end
        chk(falls == P_WARM, "R11 re-warm-up count", falls, P_WARM);
        chk(ref_owed == P_OWED, "R11 owed preserved", ref_owed, P_OWED);
        chk(deadline_err, "R10 error sticky", deadline_err, 1);
    endtask

    // R6: held grant serves the backlog back to back
    task automatic test_burst();
        int served = 0;
        int n = 0;
        logic prev_own = 1'b0;
        check_init(2'd0);
        while (ref_owed != 3 && n < 1000) begin
            @(negedge clk);
            n++;
        end
        ref_grant = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (ref_own && !prev_own) served++;
            prev_own = ref_own;
        end while ((ref_owed != 0 || ref_own) && n < 500);
        ref_grant = 1'b0;
        chk(served == 3, "R6 burst refresh count", served, 3);
        chk(ref_owed == 0 && !ref_req, "R6 backlog cleared", ref_owed, 0);
        chk(!deadline_err, "R10 no error when served", deadline_err, 0);
    endtask

    // R7: column-before-row refresh shape
    task automatic test_cbr();
        check_init(2'd0);
        run_refresh(0);
        run_refresh(0);
    endtask

    // R8: row-only refresh with row wrap
    task automatic test_ronly();
        check_init(2'd1);
        exp_row = P_WARM % (1 << P_ROW);
        for (int j = 0; j < (1 << P_ROW) + 2; j++) run_refresh(1);
    endtask

    // R9: hidden refresh shape
    task automatic test_hidden();
        check_init(2'd0);
        ref_mode = 2'd2;
        run_refresh(2);
        run_refresh(2);
    endtask

    initial begin
        test_accrual_idle();
        test_burst();
        test_cbr();
        test_ronly();
        test_hidden();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule